// File: doc/BRIEF.md
# Center-Aligned Timer Counter

This block is the counting heart of a general-purpose timer. A programmable prescaler divides the timer clock, and each divided tick moves a counter. The counter runs in one of two modes. In down mode it counts toward zero and reloads from a period value. In center mode it climbs from zero to the period value and then falls back to zero, over and over. Each wrap or turn at a boundary raises a one-cycle update pulse and sets a sticky interrupt flag. Software clears the flag.

The period value and the divider value are each held in a written copy and in a live copy. The update pulse moves the written copy into the live one. For the period value, a hold-enable input decides whether a write takes effect at once or waits for the next update. A software strobe restarts the count from zero and raises an update. A blocking input suppresses every update: no pulse, no flag and no shadow transfer.

Top module: `tmr_center_counter`

## Requirements
- R1: After reset, `count_q` is 0, `update_pulse` and `update_flag` are 0, the internal direction is up, and both live copies and the divider phase are 0.
- R2: The counter moves only on a divider tick. A tick occurs once every (live divider + 1) clocks while `count_en` is 1. While `count_en` is 0, both the counter and the divider phase hold their values.
- R3: Down mode (`center_mode` = 0): each tick decrements the counter. A tick taken at 0 loads the reload value and produces an update. `dir_down` reads 1 in this mode.
- R4: With `reload_hold_en` = 0, a write to the period value updates the live copy in the next cycle. The next reload uses the new value.
- R5: With `reload_hold_en` = 1, a written period value reaches the live copy only on an update. A down-mode reload taken at that update loads the newly transferred value.
- R6: Center mode (`center_mode` = 1): the counter rises from 0 to the live period P and then falls back to 0. `dir_down` is 1 while falling and 0 while rising. A live period of 0 holds the counter at 0.
- R7: Center mode produces an update on the tick that moves the counter from P−1 up to P (the direction turns down at that point). It also produces an update on the tick that moves it from 1 down to 0 (the direction turns up).
- R8: A `force_update` cycle clears the counter and the divider phase and sets the direction to up, in either direction of travel. It also produces an update, subject to R10.
- R9: `update_flag` is set by every counter-generated (not forced) update and stays set until a `flag_clr` cycle. When a set and a clear fall in the same cycle, the set wins.
- R10: While `update_block` is 1, no update occurs. `update_pulse` stays 0, the flag is not set, and neither live copy changes. The counter still counts, and down mode reloads from the unchanged live period.
- R11: A divider write lands only in the written copy. The tick rate changes only after the next update.
- R12: `update_pulse` is high for exactly the one cycle after the clock edge at which the update occurs. That is the same cycle in which `count_q` first shows the reloaded, turned or cleared value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_en | input | 1 | Lets the divider and counter advance |
| center_mode | input | 1 | 0 selects down counting, 1 selects up/down counting |
| reload_hold_en | input | 1 | 1 defers period writes until the next update |
| update_block | input | 1 | 1 suppresses all updates |
| force_update | input | 1 | Software strobe: restart the count and request an update |
| reload_we | input | 1 | Write strobe for the period value |
| reload_wdata | input | CNT_W | Period value to write |
| div_we | input | 1 | Write strobe for the divider value |
| div_wdata | input | DIV_W | Divider value to write (ratio is value + 1) |
| flag_clr | input | 1 | Clears the update flag |
| count_q | output | CNT_W | Current counter value |
| dir_down | output | 1 | 1 while counting down |
| update_pulse | output | 1 | One-cycle update event |
| update_flag | output | 1 | Sticky update interrupt flag |

## Verification
The bench targets three kinds of edge case:
- **Boundary ticks.** These are the down-mode wrap at zero and the two center-mode turning points. A design that fires the overflow at P instead of P−1 shifts every pulse by one tick. A design that fires the underflow at 0 stretches the period.
- **Period writes in hold mode.** A write with hold enabled, made mid-period, must leave the running period unchanged. A design that applies it at once ends the period early. A design that reloads from the old live copy at the transfer runs one extra period at the old length.
- **Blocking, forced restarts and flag races.** The bench forces updates while falling, blocks updates while writes are pending, and issues flag clears in the same cycle as events. A design that still transfers shadows while blocked changes the period too soon. One that lets the clear win drops an interrupt.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic {
      TMR_DIR_UP   = 1'b0,
      TMR_DIR_DOWN = 1'b1
   } tmr_dir_e;

   typedef enum logic {
      TMR_MODE_DOWN   = 1'b0,
      TMR_MODE_CENTER = 1'b1
   } tmr_mode_e;

   // smallest counter width the turning logic supports
   localparam int TMR_MIN_W = 2;

endpackage

// File: rtl/tmr_div_stage.sv
// Clock divider: raises tick once every (div_lim + 1) enabled cycles.
module tmr_div_stage #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] div_lim,
   output logic             tick
);

   logic [DIV_W-1:0] phase_q;

   assign tick = run && !restart && (phase_q >= div_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (restart) begin
         phase_q <= '0;
      end else if (run) begin
         phase_q <= tick ? '0 : phase_q + 1'b1;
      end
   end

endmodule

// File: rtl/tmr_shadow_pair.sv
// Written copy plus live copy; DIRECT_OK selects whether writes may bypass
// the transfer and land in the live copy straight away.
module tmr_shadow_pair #(
   parameter int W         = 16,
   parameter bit DIRECT_OK = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   input  logic         direct,
   input  logic         xfer,
   output logic [W-1:0] held_q,
   output logic [W-1:0] live_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= '0;
      end else if (we) begin
         held_q <= wdata;
      end
   end

   generate
      if (DIRECT_OK) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               live_q <= '0;
            end else if (we && direct) begin
               live_q <= wdata;
            end else if (xfer) begin
               live_q <= held_q;
            end
         end
      end else begin : g_deferred
         logic unused_direct;
         assign unused_direct = direct;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               live_q <= '0;
            end else if (xfer) begin
               live_q <= held_q;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/tmr_count_core.sv
// Counter state machine for down and center modes.
module tmr_count_core
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             center_mode,
   input  logic             restart,
   input  logic [CNT_W-1:0] reload_val,
   input  logic [CNT_W-1:0] peak,
   output logic [CNT_W-1:0] cnt_q,
   output tmr_dir_e         dir_q,
   output logic             boundary
);

   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] cnt_d;
   tmr_dir_e         dir_d;
   logic             peak_zero;
   logic             at_top;

   assign peak_zero = (peak == ZERO);
   assign at_top    = !peak_zero && (cnt_q >= peak - ONE);

   always_comb begin
      cnt_d    = cnt_q;
      dir_d    = dir_q;
      boundary = 1'b0;
      if (restart) begin
         cnt_d = ZERO;
         dir_d = TMR_DIR_UP;
      end else if (tick) begin
         if (tmr_mode_e'(center_mode) == TMR_MODE_DOWN) begin
            if (cnt_q == ZERO) begin
               cnt_d    = reload_val;
               boundary = 1'b1;
            end else begin
               cnt_d = cnt_q - ONE;
            end
         end else if (dir_q == TMR_DIR_UP) begin
            if (at_top) begin
               cnt_d    = peak;
               dir_d    = TMR_DIR_DOWN;
               boundary = 1'b1;
            end else if (!peak_zero) begin
               cnt_d = cnt_q + ONE;
            end
         end else begin
            if (cnt_q == ONE) begin
               cnt_d    = ZERO;
               dir_d    = TMR_DIR_UP;
               boundary = 1'b1;
            end else if (cnt_q == ZERO) begin
               dir_d = TMR_DIR_UP;
            end else begin
               cnt_d = cnt_q - ONE;
            end
         end
      end
      if (tmr_mode_e'(center_mode) == TMR_MODE_DOWN) begin
         dir_d = TMR_DIR_UP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= ZERO;
         dir_q <= TMR_DIR_UP;
      end else begin
         cnt_q <= cnt_d;
         dir_q <= dir_d;
      end
   end

endmodule

// File: rtl/tmr_center_counter.sv
// Top: divider, period and divider shadows, counter core, event and flag.
module tmr_center_counter
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             count_en,
   input  logic             center_mode,
   input  logic             reload_hold_en,
   input  logic             update_block,
   input  logic             force_update,
   input  logic             reload_we,
   input  logic [CNT_W-1:0] reload_wdata,
   input  logic             div_we,
   input  logic [DIV_W-1:0] div_wdata,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] count_q,
   output logic             dir_down,
   output logic             update_pulse,
   output logic             update_flag
);

   generate
      if (CNT_W < TMR_MIN_W) begin : g_bad_cnt_w
         $error("tmr_center_counter: CNT_W below minimum");
      end
      if (DIV_W < 1) begin : g_bad_div_w
         $error("tmr_center_counter: DIV_W must be positive");
      end
   endgenerate

   logic             tick;
   logic             boundary;
   logic             upd_allowed;
   logic             xfer;
   logic [CNT_W-1:0] per_held;
   logic [CNT_W-1:0] per_live;
   logic [CNT_W-1:0] reload_val;
   logic [DIV_W-1:0] div_held;
   logic [DIV_W-1:0] div_live;
   tmr_dir_e         dir_q;

   assign upd_allowed = !update_block;
   assign xfer        = (boundary || force_update) && upd_allowed;
   // a reload that coincides with a transfer takes the value being transferred
   assign reload_val  = xfer ? per_held : per_live;

   tmr_div_stage #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (count_en),
      .restart (force_update),
      .div_lim (div_live),
      .tick    (tick)
   );

   tmr_shadow_pair #(.W(CNT_W), .DIRECT_OK(1'b1)) u_per (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (reload_we),
      .wdata  (reload_wdata),
      .direct (!reload_hold_en),
      .xfer   (xfer),
      .held_q (per_held),
      .live_q (per_live)
   );

   tmr_shadow_pair #(.W(DIV_W), .DIRECT_OK(1'b0)) u_divsh (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (div_we),
      .wdata  (div_wdata),
      .direct (1'b0),
      .xfer   (xfer),
      .held_q (div_held),
      .live_q (div_live)
   );

   tmr_count_core #(.CNT_W(CNT_W)) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .center_mode (center_mode),
      .restart     (force_update),
      .reload_val  (reload_val),
      .peak        (per_live),
      .cnt_q       (count_q),
      .dir_q       (dir_q),
      .boundary    (boundary)
   );

   assign dir_down = (tmr_mode_e'(center_mode) == TMR_MODE_CENTER) ?
                     (dir_q == TMR_DIR_DOWN) : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         update_pulse <= 1'b0;
         update_flag  <= 1'b0;
      end else begin
         update_pulse <= xfer;
         if (boundary && upd_allowed) begin
            update_flag <= 1'b1;
         end else if (flag_clr) begin
            update_flag <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/tmr_center_counter_chk.sv
module tmr_center_counter_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             count_en,
   input logic             center_mode,
   input logic             update_block,
   input logic             force_update,
   input logic             flag_clr,
   input logic [CNT_W-1:0] count_q,
   input logic             dir_down,
   input logic             update_pulse,
   input logic             update_flag
);

   // R2
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!count_en && !force_update) |=> $stable(count_q));

   // R6
   falling_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (center_mode && dir_down) |-> (count_q != '0));

   // R7
   underflow_lands_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (update_pulse && center_mode && $past(center_mode) && !$past(force_update)
       && !dir_down) |-> (count_q == '0));

   // R8
   forced_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (force_update && !update_block) |=> (update_pulse && count_q == '0));

   // R9
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (update_flag && !flag_clr) |=> update_flag);

   // R9
   flag_rise_with_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(update_flag) |-> update_pulse);

   // R10
   blocked_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      update_block |=> !update_pulse);

endmodule

bind tmr_center_counter tmr_center_counter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .count_en     (count_en),
   .center_mode  (center_mode),
   .update_block (update_block),
   .force_update (force_update),
   .flag_clr     (flag_clr),
   .count_q      (count_q),
   .dir_down     (dir_down),
   .update_pulse (update_pulse),
   .update_flag  (update_flag)
);

// File: tb/tmr_center_counter_bench.sv
`timescale 1ns/100ps
module tmr_center_counter_bench;

   localparam int CW = 16;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          count_en = 1'b0;
   logic          center_mode = 1'b1;
   logic          reload_hold_en = 1'b0;
   logic          update_block = 1'b0;
   logic          force_update = 1'b0;
   logic          reload_we = 1'b0;
   logic [CW-1:0] reload_wdata = '0;
   logic          div_we = 1'b0;
   logic [DW-1:0] div_wdata = '0;
   logic          flag_clr = 1'b0;
   logic [CW-1:0] count_q;
   logic          dir_down;
   logic          update_pulse;
   logic          update_flag;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;
   string cur_req = "R1";

   // reference model state
   int m_cnt, m_dir, m_phase, m_per_held, m_per_live, m_div_held, m_div_live;
   int m_evt, m_flag;

   always #2.5 clk = ~clk;

   tmr_center_counter #(.CNT_W(CW), .DIV_W(DW)) u_tmr_center_counter (
      .clk            (clk),
      .rst_n          (rst_n),
      .count_en       (count_en),
      .center_mode    (center_mode),
      .reload_hold_en (reload_hold_en),
      .update_block   (update_block),
      .force_update   (force_update),
      .reload_we      (reload_we),
      .reload_wdata   (reload_wdata),
      .div_we         (div_we),
      .div_wdata      (div_wdata),
      .flag_clr       (flag_clr),
      .count_q        (count_q),
      .dir_down       (dir_down),
      .update_pulse   (update_pulse),
      .update_flag    (update_flag)
   );

   task automatic model_reset();
      m_cnt = 0; m_dir = 0; m_phase = 0;
      m_per_held = 0; m_per_live = 0; m_div_held = 0; m_div_live = 0;
      m_evt = 0; m_flag = 0;
   endtask

   task automatic model_step();
      int nc, nd, np, hw, tk, xf, npl;
      nc = m_cnt; nd = m_dir; np = m_phase; hw = 0;
      tk = (count_en && !force_update && (m_phase >= m_div_live)) ? 1 : 0;
      if (force_update) begin
         nc = 0; nd = 0; np = 0;
      end else begin
         if (count_en) np = tk ? 0 : m_phase + 1;
         if (tk) begin
            if (!center_mode) begin
               if (m_cnt == 0) begin
                  hw = 1;
                  nc = update_block ? m_per_live : m_per_held;
               end else nc = m_cnt - 1;
            end else if (m_dir == 0) begin
               if (m_per_live != 0 && m_cnt >= m_per_live - 1) begin
                  nc = m_per_live; nd = 1; hw = 1;
               end else if (m_per_live != 0) nc = m_cnt + 1;
            end else begin
               if (m_cnt == 1) begin
                  nc = 0; nd = 0; hw = 1;
               end else if (m_cnt == 0) nd = 0;
               else nc = m_cnt - 1;
            end
         end
      end
      if (!center_mode) nd = 0;
      xf = ((hw || force_update) && !update_block) ? 1 : 0;
      npl = m_per_live;
      if (reload_we && !reload_hold_en) npl = int'(reload_wdata);
      else if (xf) npl = m_per_held;
      if (xf) m_div_live = m_div_held;
      if (reload_we) m_per_held = int'(reload_wdata);
      if (div_we) m_div_held = int'(div_wdata);
      m_per_live = npl;
      if (hw && !update_block) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      m_evt = xf; m_cnt = nc; m_dir = nd; m_phase = np;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) model_reset();
      else model_step();
   end

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // lockstep comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cur_req, "count_q", int'(count_q), m_cnt);
         chk(cur_req, "dir_down", int'(dir_down), center_mode ? m_dir : 1);
         chk(cur_req, "update_pulse", int'(update_pulse), m_evt);
         chk(cur_req, "update_flag", int'(update_flag), m_flag);
      end
   end

   task automatic cyc(int n = 1);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic wr_reload(int v);
      reload_we = 1'b1; reload_wdata = CW'(v);
      cyc();
      reload_we = 1'b0;
   endtask

   task automatic wr_div(int v);
      div_we = 1'b1; div_wdata = DW'(v);
      cyc();
      div_we = 1'b0;
   endtask

   task automatic force_upd();
      force_update = 1'b1;
      cyc();
      force_update = 1'b0;
   endtask

   // watchdog
   initial begin
      cyc(100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      model_reset();
      cyc(3);
      rst_n = 1'b1;
      #1;
      // R1: reset state seen directly at the ports
      chk("R1", "reset count", int'(count_q), 0);
      chk("R1", "reset dir", int'(dir_down), 0);
      chk("R1", "reset pulse", int'(update_pulse), 0);
      chk("R1", "reset flag", int'(update_flag), 0);
      cyc(2);

      cur_req = "R3";
      center_mode = 1'b0;
      wr_reload(4);
      count_en = 1'b1;
      cyc(20);

      cur_req = "R4";
      wr_reload(2);
      cyc(12);

      cur_req = "R11";
      wr_div(2);
      cyc(8);
      cur_req = "R8";
      force_upd();
      cyc(20);

      cur_req = "R2";
      count_en = 1'b0;
      cyc(7);
      count_en = 1'b1;
      cyc(9);

      cur_req = "R11";
      wr_div(0);
      cyc(20);

      cur_req = "R5";
      reload_hold_en = 1'b1;
      cyc(1);
      wr_reload(6);
      cyc(25);

      cur_req = "R10";
      update_block = 1'b1;
      wr_reload(3);
      wr_div(1);
      force_upd();
      cyc(25);
      update_block = 1'b0;
      cyc(15);

      cur_req = "R9";
      flag_clr = 1'b1;
      cyc(4);
      flag_clr = 1'b0;
      cyc(6);
      flag_clr = 1'b1;
      cyc(12);
      flag_clr = 1'b0;

      cur_req = "R6";
      center_mode = 1'b1;
      reload_hold_en = 1'b0;
      wr_div(0);
      force_upd();
      wr_reload(3);
      cyc(30);

      cur_req = "R7";
      wr_reload(1);
      cyc(10);
      reload_hold_en = 1'b1;
      wr_reload(5);
      cyc(30);

      cur_req = "R8";
      force_upd();
      cyc(7);
      force_upd();
      cyc(9);

      cur_req = "R12";
      wr_div(1);
      force_upd();
      cyc(40);
      wr_reload(0);
      force_upd();
      cyc(10);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule